// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

A behavioural, synthesizable model of a synchronous static memory with a one-stage read pipeline and four-beat internal bursts. Words are 18 bits wide and stored in two 9-bit byte lanes: lane a holds bits 8:0 and lane b holds bits 17:9. All strobes and enables are active low and are registered on the rising clock edge. The model is for use in a larger design or in a system-level bench, in place of an external memory part.

A cycle starts on one of two address strobes. The processor strobe always starts a read and is gated by the master chip enable. The controller strobe starts a read or a write, depending on the write controls sampled on the same edge. When neither strobe is low, the burst advance input steps an internal two-bit counter through the aligned group of four words. The order is interleaved or linear, chosen by the burst-order input when the burst starts. Writes can cover the whole word or be masked per byte lane. Reads return data one edge after the address edge. The output drive flag drops while output enable is high and in the cycle after any byte write strobe is seen low.

The data bus is modelled as a separate input `din` and a separate output `dout`, with `dout_en` marking when the output would be driven.

Top module: `pipe_burst_sram`

## Requirements
- R1: A read access decided on edge k (any start or continue edge that does not write) loads the word at its access address into the output register on edge k+1. `dout` shows it after edge k+1, and `dout_en` is high in that cycle if `oe_n` is low and R10 does not apply.
- R2: When `ps_n` is low and all three enables (`ce0_n`, `ce1_n`, `ce2_n`) are low, a read burst starts at `addr`. On that edge `cs_n`, `gw_n`, `bwe_n`, `bw_n` and `adv_n` are ignored, so no write happens.
- R3: When `ps_n` is low and `ce0_n` is high, the edge behaves exactly as if `ps_n` were high. The controller strobe is not blocked by `ce0_n` in this way.
- R4: When the processor strobe is not in effect, `cs_n` is low and all enables are low, a burst starts at `addr`. The edge writes `din` if the write controls (R9) select any lane, and reads otherwise.
- R5: A start edge (either strobe in effect) with any enable high deselects the block. `dout_en` is low after the following edge, and continue edges perform no read or write until the next valid start.
- R6: On a continue edge (both strobes not in effect, block selected), `adv_n` low moves to the next burst address and the access uses it. `adv_n` high repeats the current address.
- R7: With `order_sel` high at the start edge, beat n uses low address bits (start low bits XOR n). The upper address bits stay fixed, and the counter wraps after four beats.
- R8: With `order_sel` low at the start edge, beat n uses low address bits (start low bits + n) mod 4, with the upper bits fixed.
- R9: On write-capable edges, `gw_n` low writes both lanes. Otherwise, if `bwe_n` is low, each lane whose `bw_n` bit is low is written (`bw_n[0]` selects lane a, `bw_n[1]` selects lane b). Otherwise nothing is written.
- R10: `dout_en` is low whenever `oe_n` is high. It is also low in the cycle after an edge on which any `bw_n` bit was low, unless that edge had the processor strobe in effect.
- R11: After reset `dout_en` is low and the block is deselected until the first valid start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ps_n | input | 1 | Processor address strobe |
| cs_n | input | 1 | Controller address strobe |
| adv_n | input | 1 | Burst advance |
| order_sel | input | 1 | Burst order: 1 interleaved, 0 linear |
| gw_n | input | 1 | Global write |
| bwe_n | input | 1 | Byte write enable |
| bw_n | input | 2 | Byte write strobes, bit 0 lane a, bit 1 lane b |
| ce0_n | input | 1 | Master chip enable |
| ce1_n | input | 1 | Chip enable |
| ce2_n | input | 1 | Chip enable |
| oe_n | input | 1 | Output enable |
| addr | input | AW | External word address |
| din | input | 18 | Write data |
| dout | output | 18 | Output register |
| dout_en | output | 1 | Output drive flag |

## Verification
The hardest case to reach is a write burst continued on the controller path while output enable stays low. It needs a prior read still in the output register, then byte strobes arriving on a continue edge whose advance and lane mask both matter. This is where the write kill of R10, byte masking and burst stepping all act in the same cycle. Directed sequences set this up on purpose: a read start followed by masked-lane continue edges, with and without the lane enable. Seeded random traffic weights the processor strobe, the master enable and partial byte strobes so that blocked and deselecting starts land in the middle of bursts. A cycle-accurate bench model predicts every cycle's output.

// File: rtl/psram_pkg.sv
package psram_pkg;

    localparam int LANE_W    = 9;
    localparam int LANES     = 2;
    localparam int WORD_W    = LANE_W * LANES;
    localparam int BEAT_BITS = 2;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_PROC,
        OP_CTRL,
        OP_DESEL,
        OP_CONT
    } op_e;

    typedef struct packed {
        op_e              op;
        logic [LANES-1:0] wmask;
        logic             bw_seen;
        logic             step;
    } cmd_t;

    function automatic logic [BEAT_BITS-1:0] beat_lo(
        input logic [BEAT_BITS-1:0] start,
        input logic [BEAT_BITS-1:0] beat,
        input logic                 interleave
    );
        if (interleave) begin
            beat_lo = start ^ beat;
        end else begin
            beat_lo = start + beat;
        end
    endfunction

    function automatic logic [LANES-1:0] lane_mask(
        input logic             gw_n,
        input logic             bwe_n,
        input logic [LANES-1:0] bw_n
    );
        if (!gw_n) begin
            lane_mask = '1;
        end else if (!bwe_n) begin
            lane_mask = ~bw_n;
        end else begin
            lane_mask = '0;
        end
    endfunction

endpackage

// File: rtl/psram_decode.sv
module psram_decode
    import psram_pkg::*;
(
    input  logic             ps_n,
    input  logic             cs_n,
    input  logic             adv_n,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bw_n,
    input  logic             ce0_n,
    input  logic             ce1_n,
    input  logic             ce2_n,
    input  logic             selected,
    output cmd_t             cmd
);

    logic proc_eff;
    logic en_all;
    logic [LANES-1:0] raw_mask;

    assign proc_eff = !ps_n && !ce0_n;
    assign en_all   = !ce0_n && !ce1_n && !ce2_n;
    assign raw_mask = lane_mask(gw_n, bwe_n, bw_n);

    always_comb begin
        cmd = '{op: OP_IDLE, wmask: '0, bw_seen: 1'b0, step: 1'b0};
        if (proc_eff) begin
            cmd.op = en_all ? OP_PROC : OP_DESEL;
        end else if (!cs_n) begin
            cmd.op = en_all ? OP_CTRL : OP_DESEL;
        end else if (selected) begin
            cmd.op = OP_CONT;
        end
        if (cmd.op == OP_CTRL || cmd.op == OP_CONT) begin
            cmd.wmask = raw_mask;
        end
        cmd.step    = (cmd.op == OP_CONT) && !adv_n;
        cmd.bw_seen = !proc_eff && (bw_n != '1);
    end

endmodule

// File: rtl/psram_burst.sv
module psram_burst
    import psram_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] addr_in,
    input  logic          order_in,
    output logic [AW-1:0] acc_addr,
    output logic [AW-1:0] held_addr
);

    logic [AW-1:0]        base_q;
    logic [BEAT_BITS-1:0] beat_q;
    logic                 inter_q;
    logic [AW-1:0]        cur_q;
    logic [BEAT_BITS-1:0] beat_nx;

    assign beat_nx   = beat_q + 1'b1;
    assign held_addr = cur_q;

    always_comb begin
        if (load) begin
            acc_addr = addr_in;
        end else if (step) begin
            acc_addr = {base_q[AW-1:BEAT_BITS],
                        beat_lo(base_q[BEAT_BITS-1:0], beat_nx, inter_q)};
        end else begin
            acc_addr = cur_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= '0;
            beat_q  <= '0;
            inter_q <= 1'b1;
            cur_q   <= '0;
        end else begin
            if (load) begin
                base_q  <= addr_in;
                beat_q  <= '0;
                inter_q <= order_in;
            end else if (step) begin
                beat_q  <= beat_nx;
            end
            cur_q <= acc_addr;
        end
    end

endmodule

// File: rtl/psram_lane.sv
module psram_lane #(
    parameter int AW = 8,
    parameter int W  = 9
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (re) begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/pipe_burst_sram.sv
module pipe_burst_sram
    import psram_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ps_n,
    input  logic              cs_n,
    input  logic              adv_n,
    input  logic              order_sel,
    input  logic              gw_n,
    input  logic              bwe_n,
    input  logic [1:0]        bw_n,
    input  logic              ce0_n,
    input  logic              ce1_n,
    input  logic              ce2_n,
    input  logic              oe_n,
    input  logic [AW-1:0]     addr,
    input  logic [17:0]       din,
    output logic [17:0]       dout,
    output logic              dout_en
);

    cmd_t          cmd;
    logic          active_q;
    logic          rd_q;
    logic [AW-1:0] rd_addr_q;
    logic          out_valid_q;
    logic          bws_q;
    logic [AW-1:0] acc_addr;
    logic [AW-1:0] held_addr;
    logic          access;
    logic          rd_now;
    logic          load;
    logic [LANES-1:0] wmask_w;

    psram_decode u_dec (
        .ps_n     (ps_n),
        .cs_n     (cs_n),
        .adv_n    (adv_n),
        .gw_n     (gw_n),
        .bwe_n    (bwe_n),
        .bw_n     (bw_n),
        .ce0_n    (ce0_n),
        .ce1_n    (ce1_n),
        .ce2_n    (ce2_n),
        .selected (active_q),
        .cmd      (cmd)
    );

    assign load    = (cmd.op == OP_PROC) || (cmd.op == OP_CTRL);
    assign access  = load || (cmd.op == OP_CONT);
    assign wmask_w = cmd.wmask;
    assign rd_now  = access && (cmd.wmask == '0);

    psram_burst #(.AW(AW)) u_burst (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .step      (cmd.step),
        .addr_in   (addr),
        .order_in  (order_sel),
        .acc_addr  (acc_addr),
        .held_addr (held_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q    <= 1'b0;
            rd_q        <= 1'b0;
            rd_addr_q   <= '0;
            out_valid_q <= 1'b0;
            bws_q       <= 1'b0;
        end else begin
            if (load) begin
                active_q <= 1'b1;
            end else if (cmd.op == OP_DESEL) begin
                active_q <= 1'b0;
            end
            rd_q        <= rd_now;
            rd_addr_q   <= acc_addr;
            out_valid_q <= rd_q;
            bws_q       <= cmd.bw_seen;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        psram_lane #(.AW(AW), .W(LANE_W)) u_lane (
            .clk   (clk),
            .we    (wmask_w[g]),
            .waddr (acc_addr),
            .wdata (din[g*LANE_W +: LANE_W]),
            .re    (rd_q),
            .raddr (rd_addr_q),
            .rdata (dout[g*LANE_W +: LANE_W])
        );
    end

    assign dout_en = out_valid_q && !oe_n && !bws_q;

endmodule

// File: rtl/pipe_burst_sram_chk.sv
module pipe_burst_sram_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          ps_n,
    input logic          cs_n,
    input logic          adv_n,
    input logic          gw_n,
    input logic          ce0_n,
    input logic          ce1_n,
    input logic          ce2_n,
    input logic          oe_n,
    input logic [1:0]    bw_n,
    input logic          dout_en,
    input logic [1:0]    wmask,
    input logic          rd_q,
    input logic [AW-1:0] held_addr
);

    logic proc_eff;
    logic en_all;
    assign proc_eff = !ps_n && !ce0_n;
    assign en_all   = !ce0_n && !ce1_n && !ce2_n;

    p_oe_gate_r10: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !dout_en);

    p_bw_kill_r10: assert property (@(posedge clk) disable iff (rst)
        (!proc_eff && bw_n != 2'b11) |=> !dout_en);

    p_proc_nowrite_r2: assert property (@(posedge clk) disable iff (rst)
        (proc_eff && en_all) |-> (wmask == 2'b00));

    p_proc_read_r2: assert property (@(posedge clk) disable iff (rst)
        (proc_eff && en_all) |=> rd_q);

    p_ctrl_write_r4: assert property (@(posedge clk) disable iff (rst)
        (!proc_eff && !cs_n && en_all && !gw_n) |-> (wmask == 2'b11));

    p_desel_r5: assert property (@(posedge clk) disable iff (rst)
        ((proc_eff || !cs_n) && !en_all) |=> ##1 !dout_en);

    p_group_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!proc_eff && cs_n && !adv_n) |=> $stable(held_addr[AW-1:2]));

endmodule

bind pipe_burst_sram pipe_burst_sram_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ps_n      (ps_n),
    .cs_n      (cs_n),
    .adv_n     (adv_n),
    .gw_n      (gw_n),
    .ce0_n     (ce0_n),
    .ce1_n     (ce1_n),
    .ce2_n     (ce2_n),
    .oe_n      (oe_n),
    .bw_n      (bw_n),
    .dout_en   (dout_en),
    .wmask     (wmask_w),
    .rd_q      (rd_q),
    .held_addr (held_addr)
);

// File: tb/tb_pipe_burst_sram.sv
module tb_pipe_burst_sram;

    localparam int AW    = 8;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst;
    logic ps_n, cs_n, adv_n, order_sel, gw_n, bwe_n, ce0_n, ce1_n, ce2_n, oe_n;
    logic [1:0]    bw_n;
    logic [AW-1:0] addr;
    logic [17:0]   din;
    logic [17:0]   dout;
    logic          dout_en;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pipe_burst_sram #(.AW(AW)) dut (
        .clk(clk), .rst(rst), .ps_n(ps_n), .cs_n(cs_n), .adv_n(adv_n),
        .order_sel(order_sel), .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n),
        .ce0_n(ce0_n), .ce1_n(ce1_n), .ce2_n(ce2_n), .oe_n(oe_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
    );

    // bench model state
    logic [17:0]   m_mem [DEPTH];
    logic          m_act, m_rdq, m_outv, m_bws, m_inter;
    logic [AW-1:0] m_base, m_cur, m_rdaddr;
    logic [1:0]    m_cnt;
    logic [17:0]   m_dout;

    function automatic logic [17:0] pat(input int a);
        return 18'((a * 1543 + 677) ^ (a << 9));
    endfunction

    function automatic logic [1:0] next_lo(input logic [1:0] s, input logic [1:0] n,
                                           input logic inter);
        return inter ? (s ^ n) : 2'(s + n);
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle_in();
        ps_n = 1; cs_n = 1; adv_n = 1; gw_n = 1; bwe_n = 1; bw_n = 2'b11;
        ce0_n = 0; ce1_n = 0; ce2_n = 0; oe_n = 0; order_sel = 1;
        addr = '0; din = '0;
    endtask

    task automatic model_edge();
        logic proc_eff, en_all;
        logic [1:0] wm;
        logic [AW-1:0] ea;
        int op; // 0 idle 1 proc 2 ctrl 3 desel 4 cont
        proc_eff = !ps_n && !ce0_n;
        en_all   = !ce0_n && !ce1_n && !ce2_n;
        m_outv = m_rdq;
        if (m_rdq) m_dout = m_mem[m_rdaddr];
        if (proc_eff) op = en_all ? 1 : 3;
        else if (!cs_n) op = en_all ? 2 : 3;
        else op = m_act ? 4 : 0;
        wm = !gw_n ? 2'b11 : (!bwe_n ? ~bw_n : 2'b00);
        if (op != 2 && op != 4) wm = 2'b00;
        ea = m_cur;
        if (op == 1 || op == 2) begin
            ea = addr; m_base = addr; m_cnt = 0; m_inter = order_sel; m_act = 1;
        end else if (op == 4 && !adv_n) begin
            m_cnt = m_cnt + 1;
            ea = {m_base[AW-1:2], next_lo(m_base[1:0], m_cnt, m_inter)};
        end else if (op == 3) begin
            m_act = 0;
        end
        if (wm[0]) m_mem[ea][8:0]  = din[8:0];
        if (wm[1]) m_mem[ea][17:9] = din[17:9];
        m_rdq    = (op == 1 || op == 2 || op == 4) && (wm == 2'b00);
        m_rdaddr = ea;
        m_cur    = ea;
        m_bws    = !proc_eff && (bw_n != 2'b11);
    endtask

    task automatic cyc(input string tag);
        logic exp_en;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        exp_en = m_outv && !oe_n && !m_bws;
        chk(dout_en == exp_en, {tag, " dout_en"}, 32'(dout_en), 32'(exp_en));
        if (exp_en) chk(dout == m_dout, {tag, " dout"}, 32'(dout), 32'(m_dout));
    endtask

    // directed burst read, returns nothing; per-cycle checks do the work
    task automatic burst_read(input logic [AW-1:0] a, input logic ord, input string tag);
        idle_in(); ps_n = 0; addr = a; order_sel = ord; gw_n = 0; cs_n = 0;
        cyc(tag);
        for (int i = 0; i < 5; i++) begin
            idle_in(); adv_n = 0; order_sel = ~ord;
            cyc(tag);
        end
        idle_in();
        cyc(tag);
    endtask

    initial begin
        idle_in();
        rst = 1;
        m_act = 0; m_rdq = 0; m_outv = 0; m_bws = 0; m_inter = 1;
        m_base = '0; m_cur = '0; m_rdaddr = '0; m_cnt = 0; m_dout = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        chk(dout_en == 1'b0, "R11 reset dout_en", 32'(dout_en), 0);

        // R11: continue edges before any start do nothing
        adv_n = 0;
        for (int i = 0; i < 3; i++) cyc("R11 no start");
        idle_in(); gw_n = 0; din = 18'h3FFFF;
        cyc("R11 write before start");

        // fill memory using controller-strobe writes (R4, R9 global)
        for (int a = 0; a < DEPTH; a++) begin
            idle_in(); cs_n = 0; gw_n = 0; addr = AW'(a); din = pat(a);
            cyc("R4 fill");
        end
        for (int a = 0; a < DEPTH; a++) m_mem[a] = pat(a);

        // R1 plain controller read then idle
        idle_in(); cs_n = 0; addr = 8'h21; cyc("R4 ctrl read");
        idle_in(); cyc("R1 latency");
        idle_in(); cyc("R1 latency");
        chk(dout == pat(8'h21), "R1 read data", 32'(dout), 32'(pat(8'h21)));

        // R7 interleaved: start low bits 1 -> 1,0,3,2 ; R8 linear -> 1,2,3,0
        burst_read(8'h45, 1'b1, "R7 interleave");
        burst_read(8'h45, 1'b0, "R8 linear");
        burst_read(8'h9E, 1'b1, "R7 interleave b");
        burst_read(8'h9E, 1'b0, "R8 linear b");

        // R2: processor start with write controls active must not write
        idle_in(); ps_n = 0; cs_n = 0; gw_n = 0; addr = 8'h30; din = 18'h0; adv_n = 0;
        bw_n = 2'b00; bwe_n = 0;
        cyc("R2 proc start");
        idle_in(); cyc("R2 proc start");
        chk(dout == pat(8'h30) && dout_en, "R2 no write on proc edge",
            32'(dout), 32'(pat(8'h30)));

        // R6: adv high repeats same address
        idle_in(); cs_n = 0; addr = 8'h52; cyc("R6 start");
        idle_in(); cyc("R6 hold");
        idle_in(); cyc("R6 hold");
        chk(dout == pat(8'h52), "R6 repeat addr", 32'(dout), 32'(pat(8'h52)));
        idle_in(); adv_n = 0; cyc("R6 step");
        idle_in(); cyc("R6 step");
        chk(dout == pat(8'h53), "R6 next addr", 32'(dout), 32'(pat(8'h53)));

        // R3: ps low with ce0 high acts as continue (advance allowed)
        idle_in(); ps_n = 0; ce0_n = 1; adv_n = 0; addr = 8'h00; cyc("R3 blocked");
        idle_in(); cyc("R3 blocked");
        chk(dout == pat(8'h50), "R3 ce0 blocks proc strobe", 32'(dout), 32'(pat(8'h50)));

        // R9: byte writes inside a write burst
        idle_in(); cs_n = 0; addr = 8'h60; bwe_n = 0; bw_n = 2'b10; din = 18'h2AAAA;
        cyc("R9 lane a start write");
        idle_in(); adv_n = 0; bwe_n = 0; bw_n = 2'b01; din = 18'h15555;
        cyc("R9 lane b burst write");
        idle_in(); adv_n = 0; bwe_n = 1; bw_n = 2'b00; din = 18'h3FFFF;
        cyc("R10 bw without bwe");
        idle_in(); cs_n = 0; addr = 8'h60; cyc("R9 readback");
        idle_in(); adv_n = 0; cyc("R9 readback");
        chk(dout == {pat(8'h60)[17:9], 9'h0AA}, "R9 lane a only",
            32'(dout), 32'({pat(8'h60)[17:9], 9'h0AA}));
        idle_in(); adv_n = 0; cyc("R9 readback");
        chk(dout == {9'h0AA, pat(8'h61)[8:0]}, "R9 lane b only",
            32'(dout), 32'({9'h0AA, pat(8'h61)[8:0]}));
        idle_in(); cyc("R9 readback");
        chk(dout == pat(8'h62), "R9 no write without bwe", 32'(dout), 32'(pat(8'h62)));

        // R10: strobe kills drive of a pending read; oe high gates
        idle_in(); cs_n = 0; addr = 8'h70; cyc("R10 start");
        idle_in(); bw_n = 2'b10; cyc("R10 bw kill");
        chk(dout_en == 1'b0, "R10 bw kills drive", 32'(dout_en), 0);
        idle_in(); oe_n = 1; cyc("R10 oe high");
        chk(dout_en == 1'b0, "R10 oe gates drive", 32'(dout_en), 0);

        // R5: deselect via controller start with ce1 high
        idle_in(); cs_n = 0; ce1_n = 1; addr = 8'h11; cyc("R5 deselect");
        idle_in(); cyc("R5 deselect");
        chk(dout_en == 1'b0, "R5 no drive after deselect", 32'(dout_en), 0);
        idle_in(); gw_n = 0; adv_n = 0; din = 18'h0; cyc("R5 no write deselected");
        idle_in(); cs_n = 0; addr = 8'h71; cyc("R5 readback");
        idle_in(); cyc("R5 readback");
        chk(dout == pat(8'h71), "R5 memory untouched", 32'(dout), 32'(pat(8'h71)));

        // constrained random traffic
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4000; i++) begin
            idle_in();
            ps_n  = ($urandom % 8) != 0;
            cs_n  = ($urandom % 6) != 0;
            ce0_n = ($urandom % 10) == 0;
            ce1_n = ($urandom % 20) == 0;
            ce2_n = ($urandom % 20) == 0;
            adv_n = $urandom % 2;
            gw_n  = ($urandom % 8) != 0;
            bwe_n = ($urandom % 3) != 0;
            bw_n  = ($urandom % 3 == 0) ? 2'($urandom) : 2'b11;
            oe_n  = ($urandom % 10) == 0;
            order_sel = $urandom % 2;
            addr  = AW'($urandom);
            din   = 18'($urandom);
            cyc("R1 R6 R9 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule